// File: doc/BRIEF.md
# Ping-Pong Block Transfer Across Unrelated Clocks

This block carries whole blocks of words from a writer clock domain to a reader clock domain whose clock has no relation to the writer's. A dual-port memory is split into two equal halves. The writer streams words into one half at consecutive offsets. Once that half holds a complete block, a single state bit is inverted and the writer carries on in the other half. Only that bit is resynchronized into the reader domain. Its edge there releases the finished half to the reader, which may then fetch the words at any offsets and in any order.

The word storage is never passed through synchronizer flops. When the reader is told a half is ready, the words in it were written at least two reader cycles earlier. They stay untouched until the writer wraps back to that half. The reader reports with a one-cycle done strobe that it has finished with a half. If another half completes before that strobe, a sticky overflow flag is raised in the reader domain.

Top module: `cdc_pingpong_buf`

## Requirements
- R1: Each accepted write (wr_en high at a wclk edge) stores wr_data at the next offset of the half being filled. Offsets count up from 0 after reset. With wr_en low, the write position does not move.
- R2: The writer fills half 0 first after reset. The fill half changes together with the write of offset 2^OFS_W-1. A half that holds fewer words than that never produces a half_rdy pulse.
- R3: Each completed half produces exactly one half_rdy pulse in the reader domain, one rclk cycle wide.
- R4: During the half_rdy pulse, and until the next pulse, half_idx gives the number of the half just completed (0 or 1). After reset the indices alternate 0, 1, 0, and so on.
- R5: The reader presents rd_ofs. One rclk edge later, rd_data holds the word written at that offset of the half named by half_idx. This holds for every offset and for any read order: forward, reversed or scrambled.
- R6: After reset in the reader domain, half_rdy and overflow are 0. No half_rdy appears until a half is completed.
- R7: A half_rdy pulse that arrives while the previous half has not been acknowledged with rd_done sets overflow. A rd_done given before the next pulse, or in the same cycle as it, avoids this. Once set, overflow stays set until rrst_n resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer clock |
| wrst_n | input | 1 | Writer synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rclk | input | 1 | Reader clock |
| rrst_n | input | 1 | Reader synchronous reset, active low |
| rd_ofs | input | OFS_W | Offset to read within the released half |
| rd_done | input | 1 | Reader has finished with the released half |
| half_rdy | output | 1 | One-cycle pulse: a half has been released |
| half_idx | output | 1 | Number of the released half |
| rd_data | output | DATA_W | Word at rd_ofs, one cycle after the address |
| overflow | output | 1 | Sticky: a half was released before the previous one was acknowledged |

## Verification
The hardest state to reach is overflow. It needs a half released while the reader still holds the previous one, so the done strobe must be withheld while the writer finishes a whole block. The stimulus reaches it on purpose only after a full round that reads without acknowledging. A second hard case is the partial half: the writer stops one step short of a block boundary, and the reader domain must stay silent for many cycles. The bench pauses the writer after five of eight words to show this. Each round walks the released half in a different offset order, so a wrong half select or address mix-up shows up as a data mismatch.

// File: rtl/cdc_pp_pkg.sv
`timescale 1ns/1ps
// Package: shared types and defaults for the ping-pong transfer block.
// Assumes: nothing; pure declarations.
package cdc_pp_pkg;
    // Names of the two memory halves.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    localparam int PP_DATA_W_DEF  = 16;
    localparam int PP_OFS_W_DEF   = 3;
    localparam int PP_SYNC_ST_DEF = 2;
endpackage

// File: rtl/pp_write_side.sv
`timescale 1ns/1ps
// Module: pp_write_side
// Writer-domain sequencer. It keeps the offset within the half being filled
// and the fill-half bit, which flips together with the last word of a half.
// Assumes: wr_en is synchronous to clk; reset is synchronous, active low.
module pp_write_side
    import cdc_pp_pkg::*;
#(
    parameter int OFS_W = PP_OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    output logic [OFS_W:0]   wr_addr,
    output logic             fill_half
);
    localparam logic [OFS_W-1:0] LAST_OFS = {OFS_W{1'b1}};

    logic [OFS_W-1:0] ofs_q;
    half_e            half_q;

    // Advance the offset on each write; change half on the last offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            half_q <= HALF_LO;
        end else if (wr_en) begin
            ofs_q <= ofs_q + 1'b1;
            if (ofs_q == LAST_OFS)
                half_q <= (half_q == HALF_LO) ? HALF_HI : HALF_LO;
        end
    end

    // Memory write address: half bit above the offset.
    always_comb begin
        wr_addr   = {half_q, ofs_q};
        fill_half = half_q;
    end

    assert_offset_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ofs_q) && $stable(fill_half));

    assert_wrap_flips_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs_q == LAST_OFS) |=> (fill_half != $past(fill_half)));
endmodule

// File: rtl/pp_toggle_sync.sv
`timescale 1ns/1ps
// Module: pp_toggle_sync
// Reader-domain receiver for the fill-half bit. It runs a synchronizer chain
// of SYNC_ST flops, then one edge register. It pulses ready while the last
// two differ and names the half the writer has just left.
// Assumes: the source bit changes at most once per several reader cycles
// (a half takes 2^OFS_W writes); SYNC_ST >= 2.
module pp_toggle_sync #(
    parameter int SYNC_ST = cdc_pp_pkg::PP_SYNC_ST_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic ready_pulse,
    output logic done_half
);
    logic [SYNC_ST-1:0] chain_q;
    logic               edge_q;
    logic               cur_tog;

    // Shift the asynchronous bit through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_ST-2:0], tog_in};
    end

    // Delay the settled bit by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= 1'b0;
        else        edge_q <= cur_tog;
    end

    // Pulse on change; the released half is the one not being filled.
    always_comb begin
        cur_tog     = chain_q[SYNC_ST-1];
        ready_pulse = cur_tog ^ edge_q;
        done_half   = ~cur_tog;
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |=> !ready_pulse);

    assert_idx_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_pulse |-> $stable(done_half));
endmodule

// File: rtl/pp_dual_ram.sv
`timescale 1ns/1ps
// Module: pp_dual_ram
// Simple dual-port memory: one write port on wclk, one registered read
// port on rclk. The contents are not reset.
// Assumes: a location is never read while the other clock writes it; the
// surrounding handshake guarantees this.
module pp_dual_ram #(
    parameter int DATA_W = cdc_pp_pkg::PP_DATA_W_DEF,
    parameter int ADDR_W = cdc_pp_pkg::PP_OFS_W_DEF + 1
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store a word on each write strobe.
    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Register the addressed word into the reader domain.
    always_ff @(posedge rclk) begin
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/pp_read_ctrl.sv
`timescale 1ns/1ps
// Module: pp_read_ctrl
// Reader-domain ownership tracker. It marks a half as held from its ready
// pulse until done, and latches overflow when a new pulse finds one held.
// Assumes: done and ready are synchronous to clk; reset is synchronous, active low.
module pp_read_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_pulse,
    input  logic done,
    output logic overflow
);
    logic held_q;
    logic ovf_q;

    // Track whether the reader still holds a released half.
    always_ff @(posedge clk) begin
        if (!rst_n)           held_q <= 1'b0;
        else if (ready_pulse) held_q <= 1'b1;
        else if (done)        held_q <= 1'b0;
    end

    // Latch overflow when a release meets a half not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovf_q <= 1'b0;
        else if (ready_pulse && held_q && !done)  ovf_q <= 1'b1;
    end

    always_comb overflow = ovf_q;

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(held_q) && $past(ready_pulse)));
endmodule

// File: rtl/cdc_pingpong_buf.sv
`timescale 1ns/1ps
// Module: cdc_pingpong_buf (top)
// Moves blocks of 2^OFS_W words from wclk to rclk through a two-half memory.
// Only the fill-half bit crosses domains; the data crosses through memory.
// Assumes: clocks are unrelated; the writer takes long enough per half that
// the reader sees each bit change (at least a few rclk cycles per half).
module cdc_pingpong_buf
    import cdc_pp_pkg::*;
#(
    parameter int DATA_W  = PP_DATA_W_DEF,
    parameter int OFS_W   = PP_OFS_W_DEF,
    parameter int SYNC_ST = PP_SYNC_ST_DEF
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [OFS_W-1:0]  rd_ofs,
    input  logic              rd_done,
    output logic              half_rdy,
    output logic              half_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              overflow
);
    localparam int ADDR_W = OFS_W + 1;

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              fill_half;
    logic              rel_half;

    pp_write_side #(.OFS_W(OFS_W)) u_wr (
        .clk      (wclk),
        .rst_n    (wrst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .fill_half(fill_half)
    );

    pp_toggle_sync #(.SYNC_ST(SYNC_ST)) u_sync (
        .clk        (rclk),
        .rst_n      (rrst_n),
        .tog_in     (fill_half),
        .ready_pulse(half_rdy),
        .done_half  (rel_half)
    );

    // Reader address: released half above the reader's offset.
    always_comb begin
        rd_addr  = {rel_half, rd_ofs};
        half_idx = rel_half;
    end

    pp_dual_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk (wclk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .rclk (rclk),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    pp_read_ctrl u_rctl (
        .clk        (rclk),
        .rst_n      (rrst_n),
        .ready_pulse(half_rdy),
        .done       (rd_done),
        .overflow   (overflow)
    );
endmodule

// File: tb/cdc_pingpong_buf_test.sv
`timescale 1ns/1ps
module cdc_pingpong_buf_test;
    localparam int DW = 16;
    localparam int OW = 3;
    localparam int HW = 1 << OW;
    // Table: {read order mode (0 fwd, 1 rev, 2 scrambled), data seed}
    localparam logic [17:0] VEC [4] = '{
        {2'd0, 16'h1000}, {2'd1, 16'hA5A5}, {2'd2, 16'h3C00}, {2'd1, 16'h0F0F}
    };

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic          wr_en = 1'b0, rd_done = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [OW-1:0] rd_ofs = '0;
    logic          half_rdy, half_idx, overflow;
    logic [DW-1:0] rd_data;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [DW-1:0] exp_mem [2][HW];
    int bh = 0, bo = 0;

    always #4 wclk = ~wclk;   // 125 MHz writer clock
    always #7 rclk = ~rclk;   // unrelated reader clock

    cdc_pingpong_buf #(.DATA_W(DW), .OFS_W(OW)) uut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rclk(rclk), .rrst_n(rrst_n), .rd_ofs(rd_ofs), .rd_done(rd_done),
        .half_rdy(half_rdy), .half_idx(half_idx), .rd_data(rd_data),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: write n words; bench models half/offset placement itself.
    task automatic write_words(input logic [DW-1:0] seed, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en   = 1'b1;
            wr_data = seed + DW'(bo * 16'h0111);
            exp_mem[bh][bo] = wr_data;
            bo++;
            if (bo == HW) begin bo = 0; bh ^= 1; end
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rdy(input int maxc, output bit got, output logic idx);
        got = 0; idx = 1'b0;
        for (int c = 0; c < maxc && !got; c++) begin
            @(negedge rclk);
            if (half_rdy) begin got = 1; idx = half_idx; end
        end
    endtask

    // R5: read every offset of a half in the given order.
    task automatic read_half(input int mode, input int half, input string req);
        for (int i = 0; i < HW; i++) begin
            int o;
            o = (mode == 0) ? i : (mode == 1) ? (HW - 1 - i) : ((i * 5 + 3) % HW);
            @(negedge rclk);
            rd_ofs = OW'(o);
            @(negedge rclk);
            check(rd_data == exp_mem[half][o], req, rd_data, exp_mem[half][o]);
        end
    endtask

    task automatic pulse_done();
        @(negedge rclk); rd_done = 1'b1;
        @(negedge rclk); rd_done = 1'b0;
    endtask

    initial begin
        bit got;
        logic idx;
        repeat (4) @(negedge rclk);
        @(negedge wclk); wrst_n = 1'b1;
        @(negedge rclk); rrst_n = 1'b1;
        // R6: reset state and silence before any completed half
        check(half_rdy == 1'b0, "R6 reset half_rdy", half_rdy, 0);
        check(overflow == 1'b0, "R6 reset overflow", overflow, 0);
        wait_rdy(12, got, idx);
        check(got == 0, "R6 no pulse at idle", got, 0);

        // Table rounds: full half, pulse, ordered readback, done.
        for (int r = 0; r < 4; r++) begin
            write_words(VEC[r][15:0], HW);
            wait_rdy(20, got, idx);
            check(got == 1, "R3 pulse per half", got, 1);
            check(idx == 1'(r % 2), "R4 half index", idx, r % 2);
            @(negedge rclk);
            check(half_rdy == 1'b0, "R3 pulse one cycle", half_rdy, 0);
            read_half(int'(VEC[r][17:16]), r % 2, "R5 readback");
            pulse_done();
        end
        check(overflow == 1'b0, "R7 no overflow with done", overflow, 0);

        // R2: a partial half must not be released.
        write_words(16'h7700, 5);
        wait_rdy(25, got, idx);
        check(got == 0, "R2 partial half silent", got, 0);
        write_words(16'h7700, 3);
        wait_rdy(20, got, idx);
        check(got == 1, "R2 completed half released", got, 1);
        check(idx == 1'b0, "R4 index after partial", idx, 0);
        read_half(0, 0, "R1 split write readback");

        // R7: withhold done, complete another half.
        write_words(16'hBEE0, HW);
        wait_rdy(20, got, idx);
        check(got == 1 && idx == 1'b1, "R4 index before overflow", idx, 1);
        @(negedge rclk);
        check(overflow == 1'b1, "R7 overflow set", overflow, 1);
        repeat (3) @(negedge rclk);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
        read_half(2, 1, "R5 readback after overflow");

        // R6: reader reset clears overflow.
        @(negedge rclk); rrst_n = 1'b0;
        repeat (2) @(negedge rclk);
        rrst_n = 1'b1;
        check(overflow == 1'b0, "R6 reset clears overflow", overflow, 0);
        check(half_rdy == 1'b0, "R6 reset clears pulse", half_rdy, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule